// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits beside the receiver, transmitter and modem-status logic of a 16550-style serial port. It collects their events, gates them with a four-bit enable register, and reduces everything still pending to one prioritized identification code. Software reads this code at offset 2. A single interrupt line leaves the block, and it is only driven while the master interrupt bit of the modem control register is set. The shifters, FIFOs and baud generator are not part of this block. They appear as event pulses and level inputs.

Each source is cleared by a different access. Line errors are cleared by reading the line status register (offset 5). Modem deltas are cleared by reading the modem status register (offset 6). The transmitter-empty condition is cleared in one of two ways: reading the identification register while it shows that code, or writing the holding register (offset 0). The received-data condition is a level. It follows the receive count compared against the trigger threshold.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the enable register and the master bit are 0 and no source is pending. Offset 2 then reads 0x01 with FIFOs off, and the interrupt line is low.
- R2: Offset 1 holds the enable bits and reads them back in bits 3:0, with bits 7:4 reading 0. The bits are: bit2 line status, bit0 received data and timeout, bit3 modem status, bit1 transmitter empty. A source whose enable bit is 0 never appears in the identification code.
- R3: In the identification byte, bit0 is 1 with nothing pending and 0 otherwise. Bits 5:4 read 0. Bits 7:6 read 11 while `fifo_en` is high and 00 otherwise.
- R4: The code in bits 3:0 is chosen by priority. Highest is 0x6 (line status), then 0x4 (received data), then 0xC (timeout), then 0x2 (transmitter empty), and lowest is 0x0 (modem status). Received data outranks timeout when both hold.
- R5: `irq_o` is high exactly when modem control bit3 is 1 and the identification code shows a pending source.
- R6: A `ls_err_evt` pulse latches a line status condition. A read of offset 5 clears it. If a new pulse arrives in the same cycle as that read, the condition stays set.
- R7: Received data holds while `rx_count >= rx_trig` with FIFOs on, or while `rx_count != 0` with FIFOs off. Timeout (0xC) shows while `rx_timeout` is high and the received-data condition is false.
- R8: A `thr_empty_evt` pulse latches the transmitter-empty condition. Two accesses clear it: a write to offset 0, or a read of offset 2 that returns code 0x2. A read of offset 2 that shows another code leaves it set. A new pulse in a clearing cycle wins.
- R9: `msr_delta` pulses accumulate into sticky bits that read at offset 6, bits 3:0. The bit order is delta CTS, delta DSR, RI trailing edge, delta DCD. Any set bit makes modem status pending. A read of offset 6 clears the bits, except bits pulsed in that same cycle.
- R10: Offset 4 stores only the master bit (bit3) and reads it back with all other bits 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | RX_LVL_W | Bytes held by the receiver |
| rx_trig | input | RX_LVL_W | Receive trigger threshold |
| rx_timeout | input | 1 | Character timeout condition |
| ls_err_evt | input | 1 | Receive line error pulse |
| thr_empty_evt | input | 1 | Holding register became empty pulse |
| msr_delta | input | 4 | Modem delta pulses |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after collisions between a new event and the access that clears it. A design where the clear wins would silently lose a line error or a modem delta. It also reads the identification register while a higher-priority code hides the transmitter-empty condition. A design that clears on any read would then drop a pending transmit interrupt. Further checks sweep the receive count across the trigger, with and without timeout and with FIFOs off, and toggle enables and the master bit. These catch an inverted comparison, a wrong timeout precedence, or an interrupt line that ignores gating.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam logic [2:0] OFS_HOLD   = 3'd0;
    localparam logic [2:0] OFS_ENABLE = 3'd1;
    localparam logic [2:0] OFS_IDENT  = 3'd2;
    localparam logic [2:0] OFS_MCTL   = 3'd4;
    localparam logic [2:0] OFS_LSTAT  = 3'd5;
    localparam logic [2:0] OFS_MSTAT  = 3'd6;

    localparam int N_EN      = 4;
    localparam int N_DELTA   = 4;
    localparam int N_SRC     = 5;
    localparam int MASTER_BIT = 3;

    // enable bit positions
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [3:0] {
        ID_LINE    = 4'h6,
        ID_RXDATA  = 4'h4,
        ID_TIMEOUT = 4'hC,
        ID_TXEMPTY = 4'h2,
        ID_MODEM   = 4'h0,
        ID_NONE    = 4'h1
    } id_code_e;

    typedef struct packed {
        logic [N_EN-1:0] en;
        logic            master;
    } ctrl_t;

    typedef struct packed {
        logic               line;
        logic               thre;
        logic [N_DELTA-1:0] delta;
    } src_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_enable,
    input  logic       wr_mctl,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_enable) ctrl_d.en     = wdata[N_EN-1:0];
        if (wr_mctl)   ctrl_d.master = wdata[MASTER_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_set,
    input  logic               line_clr,
    input  logic               thre_set,
    input  logic               thre_clr,
    input  logic [N_DELTA-1:0] delta_set,
    input  logic               delta_clr,
    output src_t               src_o
);
    src_t src_d, src_q;

    always_comb begin
        src_d = src_q;
        // a new event in the clearing cycle survives
        if (line_clr) src_d.line = 1'b0;
        if (line_set) src_d.line = 1'b1;
        if (thre_clr) src_d.thre = 1'b0;
        if (thre_set) src_d.thre = 1'b1;
        if (delta_clr) src_d.delta = '0;
        src_d.delta = src_d.delta | delta_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_d;
    end

    assign src_o = src_q;

    assert_line_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_clr && !line_set) |=> !src_q.line);
    assert_delta_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (delta_clr && (delta_set == '0)) |=> (src_q.delta == '0));
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [N_SRC-1:0] req,      // index 0 = highest priority
    output logic [N_SRC-1:0] grant,
    output id_code_e         code,
    output logic             pending
);
    function automatic id_code_e code_of(input int idx);
        case (idx)
            0:       return ID_LINE;
            1:       return ID_RXDATA;
            2:       return ID_TIMEOUT;
            3:       return ID_TXEMPTY;
            default: return ID_MODEM;
        endcase
    endfunction

    logic [N_SRC:0] blocked;

    assign blocked[0] = 1'b0;
    for (genvar g = 0; g < N_SRC; g++) begin : g_chain
        assign grant[g]     = req[g] && !blocked[g];
        assign blocked[g+1] = blocked[g] || req[g];
    end

    always_comb begin
        code = ID_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (grant[i]) code = code_of(i);
        end
    end

    assign pending = blocked[N_SRC];
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int RX_LVL_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          reg_addr,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                fifo_en,
    input  logic [RX_LVL_W-1:0] rx_count,
    input  logic [RX_LVL_W-1:0] rx_trig,
    input  logic                rx_timeout,
    input  logic                ls_err_evt,
    input  logic                thr_empty_evt,
    input  logic [N_DELTA-1:0]  msr_delta,
    output logic                irq_o
);
    ctrl_t            ctrl;
    src_t             src;
    logic [N_SRC-1:0] req, grant;
    id_code_e         code;
    logic             pending;
    logic             rx_avail;
    logic [7:0]       ident;
    logic             thre_ack;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[7:N_EN];

    uart_irq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_enable (reg_wr && reg_addr == OFS_ENABLE),
        .wr_mctl   (reg_wr && reg_addr == OFS_MCTL),
        .wdata     (reg_wdata),
        .ctrl_o    (ctrl)
    );

    assign thre_ack = reg_rd && reg_addr == OFS_IDENT && code == ID_TXEMPTY;

    uart_irq_src u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_set  (ls_err_evt),
        .line_clr  (reg_rd && reg_addr == OFS_LSTAT),
        .thre_set  (thr_empty_evt),
        .thre_clr  (thre_ack || (reg_wr && reg_addr == OFS_HOLD)),
        .delta_set (msr_delta),
        .delta_clr (reg_rd && reg_addr == OFS_MSTAT),
        .src_o     (src)
    );

    assign rx_avail = fifo_en ? (rx_count >= rx_trig) : (rx_count != '0);

    assign req[0] = src.line && ctrl.en[EN_LINE];
    assign req[1] = rx_avail && ctrl.en[EN_RX];
    assign req[2] = rx_timeout && ctrl.en[EN_RX];
    assign req[3] = src.thre && ctrl.en[EN_TX];
    assign req[4] = (|src.delta) && ctrl.en[EN_MODEM];

    uart_irq_prio u_prio (
        .req     (req),
        .grant   (grant),
        .code    (code),
        .pending (pending)
    );

    assign ident = {{2{fifo_en}}, 2'b00, code};
    assign irq_o = ctrl.master && pending;

    always_comb begin
        case (reg_addr)
            OFS_ENABLE: reg_rdata = {{(8-N_EN){1'b0}}, ctrl.en};
            OFS_IDENT:  reg_rdata = ident;
            OFS_MCTL:   reg_rdata = 8'(ctrl.master) << MASTER_BIT;
            OFS_MSTAT:  reg_rdata = {{(8-N_DELTA){1'b0}}, src.delta};
            default:    reg_rdata = 8'h00;
        endcase
    end

    assert_master_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_MCTL && !reg_wdata[MASTER_BIT]) |=> !irq_o);
    assert_line_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src.line && ctrl.en[EN_LINE]) |-> (code == ID_LINE));
    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_hold_write_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_HOLD && !thr_empty_evt) |=> !src.thre);
endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       fifo_en = 1'b0;
    logic [4:0] rx_count = '0, rx_trig = '0;
    logic       rx_timeout = 1'b0;
    logic       ls_err_evt = 1'b0, thr_empty_evt = 1'b0;
    logic [3:0] msr_delta = '0;
    logic       irq_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    bit [3:0] m_en = 0;
    bit       m_master = 0, m_line = 0, m_thre = 0;
    bit [3:0] m_delta = 0;

    always #10 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_en(fifo_en), .rx_count(rx_count), .rx_trig(rx_trig),
        .rx_timeout(rx_timeout), .ls_err_evt(ls_err_evt),
        .thr_empty_evt(thr_empty_evt), .msr_delta(msr_delta), .irq_o(irq_o)
    );

    function automatic bit [3:0] m_code();
        bit rx = fifo_en ? (rx_count >= rx_trig) : (rx_count != 0);
        if (m_line && m_en[2])         return 4'h6;
        if (rx && m_en[0])             return 4'h4;
        if (rx_timeout && m_en[0])     return 4'hC;
        if (m_thre && m_en[1])         return 4'h2;
        if ((m_delta != 0) && m_en[3]) return 4'h0;
        return 4'h1;
    endfunction

    function automatic bit [7:0] m_read(input bit [2:0] a);
        case (a)
            3'd1:    return {4'h0, m_en};
            3'd2:    return {fifo_en ? 2'b11 : 2'b00, 2'b00, m_code()};
            3'd4:    return {4'h0, m_master, 3'b000};
            3'd6:    return {4'h0, m_delta};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input bit [2:0] a, input bit rd, input bit wr,
                        input bit [7:0] wd, input bit ls, input bit th, input bit [3:0] dl);
        bit [3:0] code;
        @(negedge clk);
        reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
        ls_err_evt = ls; thr_empty_evt = th; msr_delta = dl;
        #2;
        code = m_code();
        check(req, "irq", int'(irq_o), int'(m_master && code != 4'h1));
        if (rd) check(req, "rdata", int'(reg_rdata), int'(m_read(a)));
        @(posedge clk);
        if (wr && a == 3'd1) m_en = wd[3:0];
        if (wr && a == 3'd4) m_master = wd[3];
        if (rd && a == 3'd5) m_line = 0;
        if (ls) m_line = 1;
        if ((wr && a == 3'd0) || (rd && a == 3'd2 && code == 4'h2)) m_thre = 0;
        if (th) m_thre = 1;
        if (rd && a == 3'd6) m_delta = 0;
        m_delta |= dl;
        #1;
        reg_rd = 0; reg_wr = 0; ls_err_evt = 0; thr_empty_evt = 0; msr_delta = 0;
    endtask

    task automatic rd(input string req, input bit [2:0] a);
        step(req, a, 1, 0, 0, 0, 0, 0);
    endtask
    task automatic wr(input string req, input bit [2:0] a, input bit [7:0] d);
        step(req, a, 0, 1, d, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd("R1", 3'd2); rd("R1", 3'd1); rd("R1", 3'd4);
        // R10 and R2 register access
        wr("R10", 3'd4, 8'hFF); rd("R10", 3'd4); rd("R10", 3'd7);
        wr("R2", 3'd1, 8'hFF); rd("R2", 3'd1);
        // R9 modem deltas
        step("R9", 3'd0, 0, 0, 0, 0, 0, 4'b0101);
        rd("R9", 3'd2); rd("R9", 3'd6); rd("R9", 3'd6); rd("R9", 3'd2);
        // R8 transmitter empty cleared by ident read
        step("R8", 3'd0, 0, 0, 0, 0, 1, 0);
        rd("R8", 3'd2); rd("R8", 3'd2);
        // R4 transmitter over modem
        step("R4", 3'd0, 0, 0, 0, 0, 1, 4'b1000);
        rd("R4", 3'd2); rd("R4", 3'd2); rd("R9", 3'd6);
        // R8 cleared by holding write; new pulse wins
        step("R8", 3'd0, 0, 0, 0, 0, 1, 0);
        wr("R8", 3'd0, 8'h41); rd("R8", 3'd2);
        step("R8", 3'd0, 0, 0, 0, 0, 1, 0);
        step("R8", 3'd0, 0, 1, 8'h42, 0, 1, 0); rd("R8", 3'd2);
        // R6 and R4: line status hides transmitter empty; ident read keeps it
        step("R6", 3'd0, 0, 0, 0, 1, 1, 0);
        rx_count = 5'd1;
        rd("R4", 3'd2); rd("R8", 3'd2);
        step("R6", 3'd5, 1, 0, 0, 1, 0, 0); rd("R6", 3'd2);
        rd("R6", 3'd5); rd("R7", 3'd2);
        rx_count = 5'd0;
        rd("R8", 3'd2); rd("R8", 3'd2);
        // R7 FIFO levels, R3 upper bits
        fifo_en = 1; rx_trig = 5'd8; rx_count = 5'd7;
        rd("R3", 3'd2);
        rx_count = 5'd8; rd("R7", 3'd2);
        rx_count = 5'd16; rd("R7", 3'd2);
        rx_count = 5'd7; rx_timeout = 1; rd("R7", 3'd2);
        rx_count = 5'd8; rd("R4", 3'd2);
        fifo_en = 0; rx_count = 5'd0; rd("R7", 3'd2);
        rx_timeout = 0; rd("R3", 3'd2);
        // R2 disabled sources hidden
        wr("R2", 3'd1, 8'h06); rx_count = 5'd3; rd("R2", 3'd2);
        step("R2", 3'd0, 0, 0, 0, 0, 0, 4'b0010); rd("R2", 3'd2);
        step("R2", 3'd0, 0, 0, 0, 1, 0, 0);
        wr("R2", 3'd1, 8'h0B); rd("R2", 3'd2);
        // R5 master gating
        wr("R5", 3'd4, 8'h00); rd("R5", 3'd2);
        wr("R5", 3'd4, 8'h08); rd("R5", 3'd1);
        rx_count = 5'd0; rd("R9", 3'd6); rd("R5", 3'd2);
        // R9 collision: delta in the clearing cycle survives
        step("R9", 3'd6, 1, 0, 0, 0, 0, 4'b0100); rd("R9", 3'd6); rd("R9", 3'd2);
        wr("R2", 3'd1, 8'h0F); rd("R6", 3'd5); rd("R5", 3'd2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule